// File: doc/BRIEF.md
# Nibble-Loaded Double-Buffered DAC Register

This block is the digital front end of a 10-bit parallel-input converter. A processor bus delivers a 12-bit input word in 4-bit pieces. The pieces are a high nibble, a middle nibble and a low nibble, and the low nibble holds two sub-LSB bits below two data bits. Each piece is stored in its own input latch. A bus write happens while both the chip-select and write strobes are low. The write is committed when the strobe ends, and the select lines decide which latch or latches take it. A narrow bus (4-bit) fills the word in three writes. A wide bus (8-bit) fills it in two: the low and middle nibbles together, then the high nibble.

A separate active-low update input controls the DAC register that drives the 10-bit code output. While the update input is high, the register holds its value and the input latches may be written in any order. While it is low, the register follows the input latches on every clock. It keeps the assembled word when the input rises. Every strobe is synchronised through a flop chain. The data and select lines pass through an equal chain, so they stay aligned with the strobes.

Two state machines do the work. The write machine has the states W_IDLE, W_CAPTURE and W_COMMIT:
- W_IDLE goes to W_CAPTURE when the strobes are both low.
- W_CAPTURE goes to W_COMMIT when the strobe ends.
- W_COMMIT goes back to W_CAPTURE on a new strobe, or to W_IDLE otherwise.

The update machine has the states L_HOLD, L_TRACK and L_STRETCH:
- L_HOLD goes to L_TRACK when the update input goes low.
- L_TRACK goes to L_HOLD when the update input rises and no write window is open.
- L_TRACK goes to L_STRETCH when the update input rises while a write is in flight, or while the minimum-low window after a commit has not expired.
- L_STRETCH goes to L_TRACK if the update input falls again.
- L_STRETCH goes to L_HOLD when the window closes.

Top module: `nib_dac_front`

## Requirements
- R1: A synchronous reset clears the input latches and the DAC register, so code_o reads 0 on the clock after reset is applied and stays 0 after reset is released until a write lands.
- R2: With wide_bus = 0, bus_d[3:0] is written to the low nibble for sel = 01, to the middle nibble for sel = 10, and to the high nibble for sel = 11. With sel = 00 a narrow write changes no latch.
- R3: With wide_bus = 1, sel = 00 writes bus_d[3:0] to the low nibble and bus_d[7:4] to the middle nibble in one write. sel = 11 writes bus_d[3:0] to the high nibble. sel = 01 and sel = 10 change no latch.
- R4: A write happens only while cs_n and wr_n are both low. A wr_n pulse with cs_n high changes nothing, and neither does a cs_n pulse with wr_n high.
- R5: The value committed is the one on the bus in the last cycle the strobe was held. Values changed while the strobe is held are overwritten by later values, and bus changes after the strobe ends have no effect.
- R6: While upd_n is high and no write window is open, code_o holds, whatever is written into the input latches.
- R7: When upd_n rises, the DAC register keeps the assembled input word. The high nibble may have been written first.
- R8: While upd_n is low, code_o follows the input latches. A write appears on code_o no later than 6 clocks after the strobe is released, and not earlier than 4 clocks after it.
- R9: If upd_n rises while a write is still in flight, or within MIN_LOW_CYC clocks of a commit made while it was low, the register keeps following until that window ends. The write then appears in the held code.
- R10: code_o is {high nibble, middle nibble, low nibble bits [3:2]}. Low nibble bits [1:0] never reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_bus | input | 1 | 1 selects the 8-bit two-write mode, 0 the 4-bit three-write mode |
| sel | input | 2 | Select lines choosing the target nibble latch or latches |
| bus_d | input | 8 | Bus data |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Update control: low makes the DAC register follow, and a rise keeps the word |
| code_o | output | 10 | DAC register code |

## Verification
A write machine stuck outside W_IDLE, or a wrong nibble decode, shows at the ports within six clocks of a strobe release while upd_n is low. code_o then fails to take the written nibble, or it takes the nibble in the wrong field. An update machine that leaves L_TRACK too early captures a word without its last nibble. That error stays on code_o for the whole hold period, so a check some tens of clocks later finds it. A machine that fails to return to L_HOLD lets later writes leak onto code_o while upd_n is high.

// File: rtl/ndf_pkg.sv
package ndf_pkg;

    localparam int NUM_NIB = 3;
    localparam int NIB_LO  = 0;
    localparam int NIB_MID = 1;
    localparam int NIB_HI  = 2;

    localparam logic [1:0] SEL_PAIR = 2'b00;
    localparam logic [1:0] SEL_LO   = 2'b01;
    localparam logic [1:0] SEL_MID  = 2'b10;
    localparam logic [1:0] SEL_HI   = 2'b11;

    typedef enum logic [1:0] {
        W_IDLE    = 2'd0,
        W_CAPTURE = 2'd1,
        W_COMMIT  = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        L_HOLD    = 2'd0,
        L_TRACK   = 2'd1,
        L_STRETCH = 2'd2
    } ld_state_e;

endpackage

// File: rtl/ndf_sync.sv
module ndf_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ndf_wr_fsm.sv
module ndf_wr_fsm
    import ndf_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int SUB_W = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cs_s,
    input  logic                            wr_s,
    input  logic                            wide_s,
    input  logic [1:0]                      sel_s,
    input  logic [2*NIB_W-1:0]              data_s,
    output logic [NUM_NIB*NIB_W-SUB_W-1:0]  word_o,
    output logic                            busy_o,
    output wr_state_e                       state_o
);

    localparam int BUS_W = 2 * NIB_W;

    wr_state_e          st_q;
    wr_state_e          st_d;
    logic               strobe_on;
    logic               snap_wide;
    logic [1:0]         snap_sel;
    logic [BUS_W-1:0]   snap_data;
    logic [NUM_NIB-1:0] nib_we;
    logic [NIB_W-1:0]   nib_wd [NUM_NIB];

    assign strobe_on = !cs_s && !wr_s;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= W_IDLE;
        else     st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE:    if (strobe_on) st_d = W_CAPTURE;
            W_CAPTURE: if (!strobe_on) st_d = W_COMMIT;
            W_COMMIT:  st_d = strobe_on ? W_CAPTURE : W_IDLE;
            default:   st_d = W_IDLE;
        endcase
    end

    // Bus snapshot: the last value seen while the strobe is held
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_wide <= 1'b0;
            snap_sel  <= '0;
            snap_data <= '0;
        end else if (strobe_on) begin
            snap_wide <= wide_s;
            snap_sel  <= sel_s;
            snap_data <= data_s;
        end
    end

    // Output decode: latch enables in the commit state
    always_comb begin
        nib_we = '0;
        for (int g = 0; g < NUM_NIB; g++) nib_wd[g] = snap_data[NIB_W-1:0];
        if (st_q == W_COMMIT) begin
            if (snap_wide) begin
                unique case (snap_sel)
                    SEL_PAIR: begin
                        nib_we[NIB_LO]  = 1'b1;
                        nib_we[NIB_MID] = 1'b1;
                        nib_wd[NIB_MID] = snap_data[BUS_W-1:NIB_W];
                    end
                    SEL_HI:  nib_we[NIB_HI] = 1'b1;
                    default: nib_we = '0;
                endcase
            end else begin
                unique case (snap_sel)
                    SEL_LO:  nib_we[NIB_LO]  = 1'b1;
                    SEL_MID: nib_we[NIB_MID] = 1'b1;
                    SEL_HI:  nib_we[NIB_HI]  = 1'b1;
                    default: nib_we = '0;
                endcase
            end
        end
    end

    // Input latches; the sub-LSB bits of the low nibble are not kept
    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        localparam int KEEP_LSB = (g == NIB_LO) ? SUB_W : 0;
        logic [NIB_W-1:KEEP_LSB] q;
        always_ff @(posedge clk) begin
            if (rst)            q <= '0;
            else if (nib_we[g]) q <= nib_wd[g][NIB_W-1:KEEP_LSB];
        end
        assign word_o[g*NIB_W+NIB_W-1-SUB_W : g*NIB_W+KEEP_LSB-SUB_W] = q;
    end

    assign busy_o  = (st_q != W_IDLE) || strobe_on;
    assign state_o = st_q;

endmodule

// File: rtl/ndf_ld_fsm.sv
module ndf_ld_fsm
    import ndf_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int MIN_LOW_CYC = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_s,
    input  logic              busy_i,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o,
    output ld_state_e         state_o,
    output logic              guard_zero_o
);

    localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);

    ld_state_e         st_q;
    ld_state_e         st_d;
    logic [CNT_W-1:0]  guard_q;
    logic              window_open;
    logic [CODE_W-1:0] dac_q;

    assign window_open = busy_i || (guard_q != '0);

    // Minimum-low window after a commit made while updating is enabled
    always_ff @(posedge clk) begin
        if (rst)
            guard_q <= '0;
        else if (commit_i && ((st_q != L_HOLD) || !ld_s))
            guard_q <= CNT_W'(MIN_LOW_CYC);
        else if (guard_q != '0)
            guard_q <= guard_q - 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= L_HOLD;
        else     st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            L_HOLD:    if (!ld_s) st_d = L_TRACK;
            L_TRACK:   if (ld_s) st_d = window_open ? L_STRETCH : L_HOLD;
            L_STRETCH: begin
                if (!ld_s)             st_d = L_TRACK;
                else if (!window_open) st_d = L_HOLD;
            end
            default:   st_d = L_HOLD;
        endcase
    end

    // Output register: follows outside L_HOLD, so leaving keeps the word
    always_ff @(posedge clk) begin
        if (rst)                 dac_q <= '0;
        else if (st_q != L_HOLD) dac_q <= word_i;
    end

    assign code_o       = dac_q;
    assign state_o      = st_q;
    assign guard_zero_o = (guard_q == '0);

endmodule

// File: rtl/nib_dac_front.sv
module nib_dac_front
    import ndf_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int SUB_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW_CYC = 13
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wide_bus,
    input  logic [1:0]                     sel,
    input  logic [2*NIB_W-1:0]             bus_d,
    input  logic                           cs_n,
    input  logic                           wr_n,
    input  logic                           upd_n,
    output logic [NUM_NIB*NIB_W-SUB_W-1:0] code_o
);

    localparam int BUS_W  = 2 * NIB_W;
    localparam int WORD_W = NUM_NIB * NIB_W;
    localparam int CODE_W = WORD_W - SUB_W;
    localparam int DSYN_W = 1 + 2 + BUS_W;

    logic [2:0]        ctl_s;
    logic              cs_s;
    logic              wr_s;
    logic              ld_s;
    logic [DSYN_W-1:0] dat_sync;
    logic              wide_s;
    logic [1:0]        sel_s;
    logic [BUS_W-1:0]  data_s;
    logic [CODE_W-1:0] word_code;
    logic              wr_busy;
    logic              wr_commit;
    logic              guard_zero;
    wr_state_e         wr_st;
    ld_state_e         ld_st;

    ndf_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b111)
    ) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cs_n, wr_n, upd_n}),
        .q_o (ctl_s)
    );

    ndf_sync #(
        .W       (DSYN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_dat_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({wide_bus, sel, bus_d}),
        .q_o (dat_sync)
    );

    assign {cs_s, wr_s, ld_s}       = ctl_s;
    assign {wide_s, sel_s, data_s}  = dat_sync;

    ndf_wr_fsm #(
        .NIB_W (NIB_W),
        .SUB_W (SUB_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (cs_s),
        .wr_s    (wr_s),
        .wide_s  (wide_s),
        .sel_s   (sel_s),
        .data_s  (data_s),
        .word_o  (word_code),
        .busy_o  (wr_busy),
        .state_o (wr_st)
    );

    assign wr_commit = (wr_st == W_COMMIT);

    ndf_ld_fsm #(
        .CODE_W      (CODE_W),
        .MIN_LOW_CYC (MIN_LOW_CYC)
    ) u_ld (
        .clk          (clk),
        .rst          (rst),
        .ld_s         (ld_s),
        .busy_i       (wr_busy),
        .commit_i     (wr_commit),
        .word_i       (word_code),
        .code_o       (code_o),
        .state_o      (ld_st),
        .guard_zero_o (guard_zero)
    );

endmodule

// File: rtl/ndf_chk.sv
module ndf_chk
    import ndf_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code,
    input logic [CODE_W-1:0] word,
    input ld_state_e         ld_st,
    input wr_state_e         wr_st,
    input logic              cs_s,
    input logic              wr_s,
    input logic              busy,
    input logic              guard_zero
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code == '0));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_st == L_HOLD) |=> $stable(code));

    // R8
    follow_word_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_st != L_HOLD) |=> (code == $past(word)));

    // R9
    stretch_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((ld_st != L_HOLD) && (busy || !guard_zero)) |=> (ld_st != L_HOLD));

    // R4
    strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_st == W_IDLE) && (cs_s || wr_s)) |=> (wr_st == W_IDLE));

    // R5
    commit_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_st == W_COMMIT) |-> ($past(wr_st) == W_CAPTURE));

endmodule

bind nib_dac_front ndf_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .code       (code_o),
    .word       (word_code),
    .ld_st      (ld_st),
    .wr_st      (wr_st),
    .cs_s       (cs_s),
    .wr_s       (wr_s),
    .busy       (wr_busy),
    .guard_zero (guard_zero)
);

// File: tb/nib_dac_front_tb.sv
`timescale 1ns/1ps
module nib_dac_front_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wide_bus = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [7:0] bus_d = 8'h00;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       upd_n = 1'b0;
    logic [9:0] code_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    nib_dac_front u_dut (
        .clk      (clk),
        .rst      (rst),
        .wide_bus (wide_bus),
        .sel      (sel),
        .bus_d    (bus_d),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .upd_n    (upd_n),
        .code_o   (code_o)
    );

    // {wide_bus, sel, bus_d, expected code}; upd_n held low (transparent)
    localparam logic [20:0] VEC [9] = '{
        {1'b0, 2'b01, 8'h0F, 10'h003},
        {1'b0, 2'b10, 8'h0A, 10'h02B},
        {1'b0, 2'b11, 8'h05, 10'h16B},
        {1'b0, 2'b00, 8'h0C, 10'h16B},
        {1'b1, 2'b00, 8'h96, 10'h165},
        {1'b1, 2'b11, 8'h3E, 10'h3A5},
        {1'b1, 2'b01, 8'hFF, 10'h3A5},
        {1'b1, 2'b10, 8'h00, 10'h3A5},
        {1'b0, 2'b01, 8'hF1, 10'h3A4}
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: code_o=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic w, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wide_bus = w; sel = s; bus_d = d;
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset state", code_o, 10'h000);

        // Table walk: R2 narrow decode, R3 wide decode, R10 output packing
        for (int i = 0; i < 9; i++) begin
            bus_write(VEC[i][20], VEC[i][19:18], VEC[i][17:10]);
            repeat (8) @(negedge clk);
            check(VEC[i][20] ? "R3 wide write (R10 packing)" : "R2 narrow write (R10 packing)",
                  code_o, VEC[i][9:0]);
        end

        // R4: a single strobe alone does nothing
        @(negedge clk);
        wide_bus = 1'b0; sel = 2'b01; bus_d = 8'h0C;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 write without select", code_o, 10'h3A4);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 select without write", code_o, 10'h3A4);

        // R5: last held value wins, later bus change ignored
        @(negedge clk);
        wide_bus = 1'b0; sel = 2'b10; bus_d = 8'h03;
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_d = 8'h07;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        bus_d = 8'h0F;
        repeat (8) @(negedge clk);
        check("R5 strobe-end capture", code_o, 10'h39C);

        // R8: latency while transparent
        @(negedge clk);
        wide_bus = 1'b0; sel = 2'b01; bus_d = 8'h0C;
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 not before strobe end", code_o, 10'h39C);
        repeat (3) @(negedge clk);
        check("R8 visible within 6 clocks", code_o, 10'h39F);

        // R6 hold, R7 capture with high nibble written first
        upd_n = 1'b1;
        repeat (20) @(negedge clk);
        bus_write(1'b0, 2'b11, 8'h01);
        bus_write(1'b1, 2'b00, 8'h48);
        repeat (8) @(negedge clk);
        check("R6 hold while update high", code_o, 10'h39F);
        upd_n = 1'b0;
        repeat (2) @(negedge clk);
        upd_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R7 capture on update rise", code_o, 10'h052);

        // R9: update released together with the strobe
        upd_n = 1'b0;
        repeat (5) @(negedge clk);
        wide_bus = 1'b1; sel = 2'b11; bus_d = 8'h0B;
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 stretched window keeps write", code_o, 10'h2D2);
        bus_write(1'b1, 2'b00, 8'h00);
        repeat (10) @(negedge clk);
        check("R6 hold after stretch", code_o, 10'h2D2);

        // R1: reset in mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", code_o, 10'h000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule